// File: doc/BRIEF.md
# Read Output Latency and Byte Mask Pipeline

This block is the read-side output stage of a synchronous graphics memory. Internal read data arrives together with a valid strobe in the cycle the column is accessed. The block then presents that data on its output after a programmable number of clock edges, from one to three. Each of the four data bytes has an output enable, and a separate tri-state pad stage can use it to drive the bus or release it.

Four byte-mask inputs do different things depending on the direction of the transfer. On reads they pass through a fixed two-edge pipeline and switch off output bytes. On writes they gate a per-byte write strobe in the same cycle.

A low clock enable freezes the whole pipeline. The freeze starts one edge after the low level is sampled and lasts until the enable is sampled high again.

Top module: `sgr_read_path`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, `dq_oe` is 0 and `dq_out` is 0; the pipeline holds no data.
- R2: With `cas_lat` = 1, a read sampled at edge E is presented in the cycle after E and only in that cycle, unless another read follows; back-to-back reads come out on consecutive cycles.
- R3: With `cas_lat` = 2 or 3, a read sampled at edge E is presented in the cycle that follows edge E+1 or edge E+2 respectively.
- R4: A `cas_lat` code of 0 behaves exactly like a latency of 3.
- R5: Mask bit `dqm[b]` controls data bits `8b+7 : 8b` only (bit 0 controls bits 7:0, bit 3 controls bits 31:24).
- R6: A mask bit sampled high at edge E disables its output byte for the cycle after edge E+1, whatever read occupies that cycle; a disabled byte reads as 0 on `dq_out`.
- R7: `dq_oe[b]` is 1 only when the pipeline stage chosen by the latency holds valid read data and that byte is not masked; when it is 1, the byte carries the read data unchanged.
- R8: `wr_strobe[b]` equals `wr_act` AND NOT `dqm[b]` in the same cycle, with no clock delay.
- R9: If `cke` is sampled low at edge E, then at edge E+1 the data, valid and mask stages keep their values and the read and mask inputs at E+1 are ignored; the edge at which the low level is sampled still updates the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the pipeline from the following edge |
| rd_vld | input | 1 | Read data valid in this cycle |
| rd_data | input | 32 | Internal read data |
| cas_lat | input | 2 | Latency code: 1, 2 or 3; 0 acts as 3 |
| dqm | input | 4 | Per-byte mask (bit b covers byte b) |
| wr_act | input | 1 | A write is in progress this cycle |
| dq_out | output | 32 | Output data; disabled bytes read 0 |
| dq_oe | output | 4 | Per-byte output enable |
| wr_strobe | output | 4 | Per-byte write strobe |

## Verification
The hardest case to reach from the ports is a clock-enable suspension that begins while reads and masks are still in flight. Here the rule that freezing starts one edge late decides which read and which mask survive. The stimulus drops `cke` for two cycles during a latency-3 burst and offers a fully masked read during the frozen edge. The bench then checks that this read never appears and that the reads sent before the freeze arrive intact but stretched by the suspended edges. A second difficult case is a mask that lines up with a different read than the one issued alongside it. Mask and read patterns are offset so that each mask hits the read that occupies the output two edges later.

// File: rtl/sgr_rd_pkg.sv
package sgr_rd_pkg;

  localparam int LAT_W = 2;

  // Map a latency code onto the pipeline stage count; codes outside 1..max act as max.
  function automatic int eff_lat(input logic [LAT_W-1:0] code, input int max_lat);
    int c;
    c = int'(code);
    if (c >= 1 && c <= max_lat) return c;
    return max_lat;
  endfunction

endpackage

// File: rtl/sgr_data_pipe.sv
module sgr_data_pipe #(
  parameter int DW    = 32,
  parameter int DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       in_vld,
  input  logic [DW-1:0]              in_data,
  output logic [DEPTH-1:0]           stg_vld,
  output logic [DEPTH-1:0][DW-1:0]   stg_data
);

  logic [DEPTH-1:0]         vld_q, vld_d;
  logic [DEPTH-1:0][DW-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (en) begin
      vld_d[0] = in_vld;
      dat_d[0] = in_data;
      for (int k = 1; k < DEPTH; k++) begin
        vld_d[k] = vld_q[k-1];
        dat_d[k] = dat_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign stg_vld  = vld_q;
  assign stg_data = dat_q;

endmodule

// File: rtl/sgr_mask_pipe.sv
module sgr_mask_pipe #(
  parameter int NB  = 4,
  parameter int DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NB-1:0] mask_in,
  output logic [NB-1:0] mask_out
);

  logic [DLY-1:0][NB-1:0] m_q, m_d;

  always_comb begin
    m_d = m_q;
    if (en) begin
      m_d[0] = mask_in;
      for (int k = 1; k < DLY; k++) m_d[k] = m_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= '0;
    else        m_q <= m_d;
  end

  assign mask_out = m_q[DLY-1];

endmodule

// File: rtl/sgr_out_sel.sv
module sgr_out_sel
  import sgr_rd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int BW    = 8,
  parameter int DEPTH = 3,
  localparam int NB   = DW / BW
) (
  input  logic [LAT_W-1:0]          lat_code,
  input  logic [DEPTH-1:0]          stg_vld,
  input  logic [DEPTH-1:0][DW-1:0]  stg_data,
  input  logic [NB-1:0]             mask,
  output logic [DW-1:0]             dq_out,
  output logic [NB-1:0]             dq_oe
);

  logic          sel_vld;
  logic [DW-1:0] sel_data;
  int            lat_eff;

  always_comb begin
    lat_eff  = eff_lat(lat_code, DEPTH);
    sel_vld  = 1'b0;
    sel_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k + 1 == lat_eff) begin
        sel_vld  = stg_vld[k];
        sel_data = stg_data[k];
      end
    end
  end

  genvar b;
  for (b = 0; b < NB; b++) begin : g_byte
    assign dq_oe[b]             = sel_vld & ~mask[b];
    assign dq_out[b*BW +: BW]   = dq_oe[b] ? sel_data[b*BW +: BW] : '0;
  end

endmodule

// File: rtl/sgr_read_path.sv
module sgr_read_path
  import sgr_rd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int MAX_LAT  = 3,
  parameter int MASK_DLY = 2,
  localparam int NBYTE   = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LAT_W-1:0]  cas_lat,
  input  logic [NBYTE-1:0]  dqm,
  input  logic              wr_act,
  output logic [DATA_W-1:0] dq_out,
  output logic [NBYTE-1:0]  dq_oe,
  output logic [NBYTE-1:0]  wr_strobe
);

  logic                         cke_q;
  logic                         pipe_en;
  logic [MAX_LAT-1:0]           stg_vld;
  logic [MAX_LAT-1:0][DATA_W-1:0] stg_data;
  logic [NBYTE-1:0]             rd_mask;

  // Suspension takes effect one edge after cke is sampled low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign pipe_en = cke_q;

  sgr_data_pipe #(.DW(DATA_W), .DEPTH(MAX_LAT)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pipe_en),
    .in_vld   (rd_vld),
    .in_data  (rd_data),
    .stg_vld  (stg_vld),
    .stg_data (stg_data)
  );

  sgr_mask_pipe #(.NB(NBYTE), .DLY(MASK_DLY)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pipe_en),
    .mask_in  (dqm),
    .mask_out (rd_mask)
  );

  sgr_out_sel #(.DW(DATA_W), .BW(BYTE_W), .DEPTH(MAX_LAT)) u_sel (
    .lat_code (cas_lat),
    .stg_vld  (stg_vld),
    .stg_data (stg_data),
    .mask     (rd_mask),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  assign wr_strobe = {NBYTE{wr_act}} & ~dqm;

endmodule

// File: rtl/sgr_read_path_chk.sv
module sgr_read_path_chk #(
  parameter int DATA_W = 32,
  parameter int NBYTE  = 4,
  parameter int LAT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [LAT_W-1:0]  cas_lat,
  input logic [NBYTE-1:0]  dqm,
  input logic              wr_act,
  input logic [DATA_W-1:0] dq_out,
  input logic [NBYTE-1:0]  dq_oe,
  input logic [NBYTE-1:0]  wr_strobe
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (dq_oe == '0 && dq_out == '0)); // R1

  AST_MASK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(cke, 2) && $past(cke, 3)) |-> (($past(dqm, 2) & dq_oe) == '0)); // R6

  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe & dqm) == '0); // R8

  AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |-> (wr_strobe == '0)); // R8

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && !$past(cke, 2) && $stable(cas_lat)) |-> ($stable(dq_oe) && $stable(dq_out))); // R9

endmodule

bind sgr_read_path sgr_read_path_chk #(
  .DATA_W (DATA_W),
  .NBYTE  (NBYTE),
  .LAT_W  (2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cas_lat   (cas_lat),
  .dqm       (dqm),
  .wr_act    (wr_act),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .wr_strobe (wr_strobe)
);

// File: tb/sgr_read_path_tb.sv
`timescale 1ns/1ps
module sgr_read_path_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic [1:0]  cas_lat;
  logic [3:0]  dqm;
  logic        wr_act;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;
  logic [3:0]  wr_strobe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sgr_read_path u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .rd_vld(rd_vld), .rd_data(rd_data),
    .cas_lat(cas_lat), .dqm(dqm), .wr_act(wr_act),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_strobe(wr_strobe)
  );

  typedef struct packed {
    logic        cke;
    logic        rdv;
    logic [1:0]  lat;
    logic [3:0]  dqm;
    logic        wr;
    logic [31:0] dat;
    logic [3:0]  ws;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,2'd1,4'b0000,1'b0,32'hA1A1A1A1,4'b0000,4'd2},
    '{1'b1,1'b0,2'd1,4'b0000,1'b0,32'h00000000,4'b0000,4'd2},
    '{1'b1,1'b1,2'd1,4'b0000,1'b0,32'hB2B2B2B2,4'b0000,4'd2},
    '{1'b1,1'b1,2'd1,4'b0000,1'b0,32'hC3C3C3C3,4'b0000,4'd2},
    '{1'b1,1'b0,2'd2,4'b0000,1'b0,32'h00000000,4'b0000,4'd3},
    '{1'b1,1'b1,2'd2,4'b0000,1'b0,32'hD4D4D4D4,4'b0000,4'd3},
    '{1'b1,1'b0,2'd2,4'b0000,1'b0,32'h00000000,4'b0000,4'd3},
    '{1'b1,1'b0,2'd2,4'b0000,1'b0,32'h00000000,4'b0000,4'd3},
    '{1'b1,1'b1,2'd3,4'b0000,1'b0,32'hE5E5E5E5,4'b0000,4'd3},
    '{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd3},
    '{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd3},
    '{1'b1,1'b1,2'd0,4'b0000,1'b0,32'hF6F6F6F6,4'b0000,4'd4},
    '{1'b1,1'b0,2'd0,4'b0000,1'b0,32'h00000000,4'b0000,4'd4},
    '{1'b1,1'b0,2'd0,4'b0000,1'b0,32'h00000000,4'b0000,4'd4},
    '{1'b1,1'b1,2'd2,4'b0001,1'b1,32'h12345678,4'b1110,4'd5},
    '{1'b1,1'b0,2'd2,4'b0100,1'b1,32'h00000000,4'b1011,4'd5},
    '{1'b1,1'b1,2'd2,4'b1000,1'b0,32'h9ABCDEF0,4'b0000,4'd6},
    '{1'b1,1'b1,2'd2,4'b0010,1'b0,32'h11223344,4'b0000,4'd6},
    '{1'b1,1'b1,2'd2,4'b0000,1'b0,32'h55667788,4'b0000,4'd6},
    '{1'b1,1'b0,2'd2,4'b1111,1'b1,32'h00000000,4'b0000,4'd8},
    '{1'b1,1'b1,2'd1,4'b0000,1'b1,32'hAABBCCDD,4'b1111,4'd7},
    '{1'b1,1'b1,2'd3,4'b0000,1'b0,32'h01020304,4'b0000,4'd9},
    '{1'b0,1'b1,2'd3,4'b0000,1'b0,32'h05060708,4'b0000,4'd9},
    '{1'b0,1'b1,2'd3,4'b1111,1'b0,32'hDEADBEEF,4'b0000,4'd9},
    '{1'b1,1'b1,2'd3,4'b0000,1'b0,32'hCAFEF00D,4'b0000,4'd9},
    '{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd9},
    '{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd9},
    '{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd9}
  };

  // History of sampled edges since the last reset release.
  int          n_edges = 0;
  bit          act_h [64];
  bit          cke_h [64];
  bit          rdv_h [64];
  logic [31:0] dat_h [64];
  logic [3:0]  dqm_h [64];

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic record_edge();
    act_h[n_edges] = (n_edges == 0) ? 1'b1 : cke_h[n_edges-1];
    cke_h[n_edges] = cke;
    rdv_h[n_edges] = rd_vld;
    dat_h[n_edges] = rd_data;
    dqm_h[n_edges] = dqm;
    n_edges++;
  endtask

  // Expected outputs after the last recorded edge, from the requirement text.
  task automatic predict(input logic [1:0] lat, output logic [3:0] eoe, output logic [31:0] eout);
    int l;
    int found;
    int a_l;
    int a_m;
    bit v;
    logic [3:0] m;
    l = (lat >= 2'd1 && lat <= 2'd3) ? int'(lat) : 3;
    found = 0; a_l = -1; a_m = -1;
    for (int e = n_edges - 1; e >= 0; e--) begin
      if (act_h[e]) begin
        found++;
        if (found == l) a_l = e;
        if (found == 2) a_m = e;
      end
    end
    v = (a_l >= 0) ? rdv_h[a_l] : 1'b0;
    m = (a_m >= 0) ? dqm_h[a_m] : 4'b0000;
    for (int b = 0; b < 4; b++) begin
      eoe[b] = v & ~m[b];
      eout[b*8 +: 8] = eoe[b] ? dat_h[a_l][b*8 +: 8] : 8'h00;
    end
  endtask

  task automatic apply(input vec_t v);
    logic [3:0]  eoe;
    logic [31:0] eout;
    cke = v.cke; rd_vld = v.rdv; cas_lat = v.lat; dqm = v.dqm; wr_act = v.wr; rd_data = v.dat;
    #1;
    check(wr_strobe == v.ws, "R8", "wr_strobe", {32'h0, wr_strobe}, {32'h0, v.ws});
    @(posedge clk);
    record_edge();
    @(negedge clk);
    predict(cas_lat, eoe, eout);
    check(dq_oe == eoe && dq_out == eout, tag_name(v.tag), "oe/data",
          {dq_oe, dq_out}, {eoe, eout});
  endtask

  task automatic idle_inputs();
    cke = 1'b1; rd_vld = 1'b0; rd_data = '0; cas_lat = 2'd1; dqm = '0; wr_act = 1'b0;
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dq_oe == 4'h0 && dq_out == 32'h0, "R1", "during reset", {dq_oe, dq_out}, 36'h0);
    rst_n = 1'b1;
    n_edges = 0;
    @(posedge clk);
    record_edge();
    @(negedge clk);
    check(dq_oe == 4'h0 && dq_out == 32'h0, "R1", "first edge", {dq_oe, dq_out}, 36'h0);

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // Reset in the middle of a latency-3 read stream.
    apply('{1'b1,1'b1,2'd3,4'b0000,1'b0,32'h77777777,4'b0000,4'd3});
    apply('{1'b1,1'b1,2'd3,4'b0000,1'b0,32'h88888888,4'b0000,4'd3});
    #1 rst_n = 1'b0;
    #1 check(dq_oe == 4'h0 && dq_out == 32'h0, "R1", "mid-run reset", {dq_oe, dq_out}, 36'h0);
    idle_inputs();
    cas_lat = 2'd3;
    @(negedge clk);
    rst_n = 1'b1;
    n_edges = 0;
    apply('{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd1});
    apply('{1'b1,1'b0,2'd3,4'b0000,1'b0,32'h00000000,4'b0000,4'd1});
    // Pipeline works again after reset: single byte masked at latency 1 with mask one edge earlier.
    apply('{1'b1,1'b0,2'd1,4'b1000,1'b0,32'h00000000,4'b0000,4'd6});
    apply('{1'b1,1'b1,2'd1,4'b0000,1'b0,32'h13579BDF,4'b0000,4'd6});
    apply('{1'b1,1'b0,2'd1,4'b0000,1'b0,32'h00000000,4'b0000,4'd2});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule